// File: doc/BRIEF.md
# Type-0 Configuration Address Translator

This block sits between a host-side register window and a downstream configuration port of a bus bridge. A host access carries a 16-bit offset into the configuration window. The block joins that offset with the low half of a programmable map value to form a 32-bit working address. It then rebuilds that address as a bus configuration address. The device number comes from the position of the lowest set bit of a one-hot select field. The function and register numbers are carried across unchanged. The bus number is a static input, and the top bit is set as the enable.

Accesses of one, two or four bytes are accepted. A forwarded access goes out on a valid/ready request port. A read holds the host response until the downstream read data comes back. Each forwarded completion is marked by a one-cycle pulse that tells the bridge to clear its received-master-abort and received-target-abort status bits. The map value can mark the cycle type as unsupported. When it does, writes are dropped and reads return all-ones. A working address whose select field is empty is illegal. It is not forwarded and it sets a sticky error flag, which a clear input resets.

Top module: `cfg_type0_xlate`

## Requirements
- R1: After reset `host_ready` is 1, and `dn_valid`, `rsp_valid`, `err_flag` and `abort_clr` are all 0.
- R2: The working address is `{cfg_map[15:0], host_off[15:0]}`. The forwarded `dn_addr` is bit 31 = 1, bits [30:24] = 0, bits [23:16] = `bus_num`, bits [15:11] = device number, bits [10:8] = working bits [10:8], bits [7:2] = working bits [7:2], and bits [1:0] = 0.
- R3: The device number is the index (0 to 20) of the lowest set bit of working-address bits [31:11]. Index 0 is working bit 11.
- R4: When `cfg_map[16]` is 1, nothing is forwarded. The host gets a response one cycle after acceptance. For a write its data is 0. For a read its data is all-ones sized by `host_size`: code 0 gives 0x000000FF, code 1 gives 0x0000FFFF, and code 2 gives 0xFFFFFFFF.
- R5: When `cfg_map[16]` is 0 and working bits [31:11] are all zero, nothing is forwarded and `err_flag` is set. The response is the same as in R4.
- R6: `err_flag` stays set until `err_clr` is sampled high. A new error in the same cycle as `err_clr` leaves the flag set.
- R7: A forwarded read responds with `rsp_valid` in the cycle after `dn_rvalid`, with `rsp_data` equal to `dn_rdata`.
- R8: `dn_valid` and every request field stay stable until `dn_ready`. Each accepted access is handed over exactly once. A forwarded write responds, with data 0, in the cycle after the handshake.
- R9: `abort_clr` pulses for exactly one cycle together with the response of every forwarded access, and never for a dropped one.
- R10: `dn_size` equals `host_size` (0, 1 or 2 for 1, 2 or 4 bytes). `dn_lane` equals `host_off[1:0]`, `dn_we` equals `host_we`, and `dn_wdata` equals `host_wdata`.
- R11: `host_ready` is 0 from acceptance of a forwarded access until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_num | input | 8 | Static bus number placed in the outgoing address |
| cfg_map | input | 17 | Map value: [15:0] upper working half, [16] unsupported-cycle flag |
| err_clr | input | 1 | Clears the sticky error flag |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_off | input | 16 | Offset within the configuration window |
| host_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| host_wdata | input | 32 | Write data |
| host_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | One-cycle host response strobe |
| rsp_data | output | 32 | Read data or all-ones fill; 0 for writes |
| err_flag | output | 1 | Sticky illegal-address flag |
| abort_clr | output | 1 | Pulse: clear received-abort status bits |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_we | output | 1 | Downstream write flag |
| dn_addr | output | 32 | Translated configuration address |
| dn_size | output | 2 | Access size code |
| dn_lane | output | 2 | Byte offset within the word |
| dn_wdata | output | 32 | Write data |
| dn_rvalid | input | 1 | Downstream read data valid |
| dn_rdata | input | 32 | Downstream read data |

## Verification
The assertions take three things for granted. The host never offers size code 3. The downstream side raises `dn_rvalid` only while a read is outstanding. `bus_num` and `cfg_map` are stable while a request is being accepted. The stimulus keeps to these: it issues only size codes 0 to 2 and changes the map and bus number only while the block is idle. Its downstream responder returns read data once per handshaken read, after a varying delay. It also varies the handshake latency, so that both request holding and response timing are exercised.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int OFF_W   = 16;
  localparam int MAP_W   = 16;
  localparam int BUS_W   = 8;
  localparam int SIZE_W  = 2;
  localparam int SEL_LSB = 11;
  localparam int SEL_W   = ADDR_W - SEL_LSB;
  localparam int DEV_W   = 5;
  localparam int FN_W    = 3;
  localparam int REG_W   = 6;
  localparam int LANE_W  = 2;

  typedef struct packed {
    logic              we;
    logic [SIZE_W-1:0] size;
    logic [LANE_W-1:0] lane;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } dn_req_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } xl_state_e;

  function automatic logic [DATA_W-1:0] fill_ones(input logic [SIZE_W-1:0] sz);
    logic [DATA_W-1:0] v;
    case (sz)
      2'd0:    v = DATA_W'(32'h0000_00FF);
      2'd1:    v = DATA_W'(32'h0000_FFFF);
      default: v = '1;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/cfgx_sel_enc.sv
module cfgx_sel_enc #(
  parameter int W     = 21,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     sel,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (sel[i]) idx = IDX_W'(i);
    end
  end

  assign any = |sel;
endmodule

// File: rtl/cfgx_addr_map.sv
module cfgx_addr_map
  import cfgx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [OFF_W-1:0]  host_off,
  input  logic [MAP_W-1:0]  map_hi,
  input  logic [BUS_W-1:0]  bus_num,
  output logic [ADDR_W-1:0] xl_addr,
  output logic              sel_zero
);
  localparam int IDX_W = $clog2(SEL_W);

  logic [ADDR_W-1:0] work;
  logic [SEL_W-1:0]  sel;
  logic [IDX_W-1:0]  dev_idx;
  logic              sel_any;

  assign work = {map_hi, host_off};
  assign sel  = work[ADDR_W-1:SEL_LSB];

  cfgx_sel_enc #(.W(SEL_W), .IDX_W(IDX_W)) u_enc (
    .sel (sel),
    .idx (dev_idx),
    .any (sel_any)
  );

  assign sel_zero = !sel_any;

  assign xl_addr = {1'b1,
                    {(ADDR_W - 1 - BUS_W - DEV_W - FN_W - REG_W - 2){1'b0}},
                    bus_num,
                    DEV_W'(dev_idx),
                    work[SEL_LSB-1 -: FN_W],
                    work[2 +: REG_W],
                    2'b00};

  AST_LOWEST_SEL: assert property (@(posedge clk) disable iff (rst)
    sel_any |-> (sel[dev_idx] && ((sel & ((SEL_W'(1) << dev_idx) - SEL_W'(1))) == '0))); // R3
endmodule

// File: rtl/cfgx_ctl.sv
module cfgx_ctl
  import cfgx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [SIZE_W-1:0] host_size,
  input  logic [LANE_W-1:0] host_lane,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              unsup,
  input  logic              sel_zero,
  input  logic [ADDR_W-1:0] xl_addr,
  input  logic              err_clr,
  input  logic              dn_ready,
  input  logic              dn_rvalid,
  input  logic [DATA_W-1:0] dn_rdata,
  output logic              host_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              err_flag,
  output logic              abort_clr,
  output logic              dn_valid,
  output dn_req_t           dn_req
);
  xl_state_e state;
  logic      accept;

  assign host_ready = (state == ST_IDLE);
  assign accept     = host_req && host_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      err_flag  <= 1'b0;
      abort_clr <= 1'b0;
      dn_valid  <= 1'b0;
      dn_req    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      abort_clr <= 1'b0;
      if (err_clr) err_flag <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (host_req) begin
            if (unsup || sel_zero) begin
              rsp_valid <= 1'b1;
              rsp_data  <= host_we ? '0 : fill_ones(host_size);
              if (!unsup) err_flag <= 1'b1;
            end else begin
              dn_valid     <= 1'b1;
              dn_req.we    <= host_we;
              dn_req.size  <= host_size;
              dn_req.lane  <= host_lane;
              dn_req.addr  <= xl_addr;
              dn_req.wdata <= host_wdata;
              state        <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (dn_ready) begin
            dn_valid <= 1'b0;
            if (dn_req.we) begin
              rsp_valid <= 1'b1;
              rsp_data  <= '0;
              abort_clr <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (dn_rvalid) begin
            rsp_valid <= 1'b1;
            rsp_data  <= dn_rdata;
            abort_clr <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    accept |-> (host_size != 2'd3)); // R10

  AST_UNSUP_DROP: assert property (@(posedge clk) disable iff (rst)
    (accept && unsup) |=> (!dn_valid && rsp_valid)); // R4

  AST_ZERO_SEL_ERR: assert property (@(posedge clk) disable iff (rst)
    (accept && !unsup && sel_zero) |=> (err_flag && !dn_valid && rsp_valid)); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> err_flag); // R6

  AST_READ_RSP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && dn_rvalid) |=> (rsp_valid && rsp_data == $past(dn_rdata))); // R7

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_req))); // R8

  AST_CLR_WITH_RSP: assert property (@(posedge clk) disable iff (rst)
    abort_clr |-> (rsp_valid && !$past(abort_clr))); // R9

  AST_BUSY_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> !host_ready); // R11
endmodule

// File: rtl/cfg_type0_xlate.sv
module cfg_type0_xlate
  import cfgx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  bus_num,
  input  logic [MAP_W:0]    cfg_map,
  input  logic              err_clr,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [OFF_W-1:0]  host_off,
  input  logic [SIZE_W-1:0] host_size,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              err_flag,
  output logic              abort_clr,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_we,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [SIZE_W-1:0] dn_size,
  output logic [LANE_W-1:0] dn_lane,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_rvalid,
  input  logic [DATA_W-1:0] dn_rdata
);
  logic [ADDR_W-1:0] xl_addr;
  logic              sel_zero;
  dn_req_t           req;

  cfgx_addr_map u_map (
    .clk      (clk),
    .rst      (rst),
    .host_off (host_off),
    .map_hi   (cfg_map[MAP_W-1:0]),
    .bus_num  (bus_num),
    .xl_addr  (xl_addr),
    .sel_zero (sel_zero)
  );

  cfgx_ctl u_ctl (
    .clk        (clk),
    .rst        (rst),
    .host_req   (host_req),
    .host_we    (host_we),
    .host_size  (host_size),
    .host_lane  (host_off[LANE_W-1:0]),
    .host_wdata (host_wdata),
    .unsup      (cfg_map[MAP_W]),
    .sel_zero   (sel_zero),
    .xl_addr    (xl_addr),
    .err_clr    (err_clr),
    .dn_ready   (dn_ready),
    .dn_rvalid  (dn_rvalid),
    .dn_rdata   (dn_rdata),
    .host_ready (host_ready),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .err_flag   (err_flag),
    .abort_clr  (abort_clr),
    .dn_valid   (dn_valid),
    .dn_req     (req)
  );

  assign dn_we    = req.we;
  assign dn_addr  = req.addr;
  assign dn_size  = req.size;
  assign dn_lane  = req.lane;
  assign dn_wdata = req.wdata;

  AST_ADDR_FRAME: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> (dn_addr[31] && dn_addr[30:24] == '0 && dn_addr[1:0] == 2'b00 &&
                  dn_addr[23:16] == bus_num)); // R2
endmodule

// File: tb/cfg_type0_xlate_test.sv
module cfg_type0_xlate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_num = 8'h3C;
  logic [16:0] cfg_map = '0;
  logic        err_clr = 1'b0;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [15:0] host_off = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ready, rsp_valid, err_flag, abort_clr, dn_valid, dn_we;
  logic [31:0] rsp_data, dn_addr, dn_wdata;
  logic [1:0]  dn_size, dn_lane;
  logic        dn_ready = 1'b0;
  logic        dn_rvalid = 1'b0;
  logic [31:0] dn_rdata = '0;

  always #2 clk = ~clk;

  cfg_type0_xlate uut (.*);

  typedef struct { logic [31:0] addr; logic we; logic [1:0] sz; logic [1:0] lane; logic [31:0] wd; } dn_exp_t;
  typedef struct { logic [31:0] data; logic clr; int kind; } rsp_exp_t;

  dn_exp_t  dq[$];
  rsp_exp_t rq[$];
  int n_chk = 0;
  int n_err = 0;
  int rsp_cnt = 0;
  int lat_seq = 0;
  logic exp_err = 1'b0;
  logic finished = 1'b0;

  function automatic logic [31:0] rd_pattern(input logic [31:0] a);
    return a ^ 32'h5A5A_1234;
  endfunction

  function automatic logic [31:0] ones_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'h0000_00FF : (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: computes expectations from the requirements, then issues the access.
  task automatic xact(input logic we, input logic [16:0] map, input logic [15:0] off,
                      input logic [1:0] sz, input logic [31:0] wd, input logic clr_too);
    logic [31:0] work;
    logic [20:0] sel;
    logic [4:0]  dev;
    logic [31:0] a;
    int target;
    work = {map[15:0], off};
    sel  = work[31:11];
    dev  = '0;
    for (int i = 20; i >= 0; i--) if (sel[i]) dev = 5'(i);
    a = {1'b1, 7'd0, bus_num, dev, work[10:8], work[7:2], 2'b00};
    if (map[16]) begin
      rq.push_back('{we ? 32'h0 : ones_of(sz), 1'b0, 0});
      if (clr_too) exp_err = 1'b0;
    end else if (sel == '0) begin
      rq.push_back('{we ? 32'h0 : ones_of(sz), 1'b0, 0});
      exp_err = 1'b1;
    end else begin
      dq.push_back('{a, we, sz, off[1:0], wd});
      rq.push_back('{we ? 32'h0 : rd_pattern(a), 1'b1, we ? 1 : 2});
      if (clr_too) exp_err = 1'b0;
    end
    target = rsp_cnt + 1;
    @(posedge clk); #1;
    cfg_map = map; host_off = off; host_we = we; host_size = sz; host_wdata = wd;
    host_req = 1'b1; err_clr = clr_too;
    do @(negedge clk); while (!host_ready);
    @(posedge clk); #1;
    host_req = 1'b0; err_clr = 1'b0;
    wait (rsp_cnt >= target);
    @(negedge clk);
    chk("R6 err_flag after access", {31'd0, err_flag}, {31'd0, exp_err});
  endtask

  task automatic clear_err();
    @(posedge clk); #1 err_clr = 1'b1;
    @(posedge clk); #1 err_clr = 1'b0;
    exp_err = 1'b0;
    @(negedge clk);
    chk("R6 err_flag cleared", {31'd0, err_flag}, 32'd0);
  endtask

  // Downstream responder with varying latency.
  initial begin
    forever begin
      @(negedge clk);
      if (dn_valid && !dn_ready) begin
        logic [31:0] a;
        logic w;
        int lat;
        lat = lat_seq % 3;
        lat_seq++;
        repeat (lat + 1) @(posedge clk);
        #1 dn_ready = 1'b1;
        a = dn_addr; w = dn_we;
        @(posedge clk); #1 dn_ready = 1'b0;
        if (!w) begin
          repeat (lat) @(posedge clk);
          #1 dn_rvalid = 1'b1; dn_rdata = rd_pattern(a);
          @(posedge clk); #1 dn_rvalid = 1'b0; dn_rdata = '0;
        end
      end
    end
  end

  // Monitor: pops expectations as the design produces results.
  initial begin
    logic prev_hs;
    logic prev_rv;
    prev_hs = 1'b0; prev_rv = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (dn_valid && dn_ready) begin
          if (dq.size() == 0) begin
            chk("R4/R5/R8 unexpected forward addr", dn_addr, 32'hxxxx_xxxx);
          end else begin
            dn_exp_t e;
            e = dq.pop_front();
            chk("R2/R3 dn_addr", dn_addr, e.addr);
            chk("R10 dn_we", {31'd0, dn_we}, {31'd0, e.we});
            chk("R10 dn_size", {30'd0, dn_size}, {30'd0, e.sz});
            chk("R10 dn_lane", {30'd0, dn_lane}, {30'd0, e.lane});
            if (e.we) chk("R10 dn_wdata", dn_wdata, e.wd);
            chk("R11 host_ready busy", {31'd0, host_ready}, 32'd0);
          end
        end
        if (rsp_valid) begin
          if (rq.size() == 0) begin
            chk("R9 unexpected response", rsp_data, 32'hxxxx_xxxx);
          end else begin
            rsp_exp_t r;
            r = rq.pop_front();
            chk("R4/R5/R7/R8 rsp_data", rsp_data, r.data);
            chk("R9 abort_clr", {31'd0, abort_clr}, {31'd0, r.clr});
            if (r.kind == 1) chk("R8 write rsp timing", {31'd0, prev_hs}, 32'd1);
            if (r.kind == 2) chk("R7 read rsp timing", {31'd0, prev_rv}, 32'd1);
          end
          rsp_cnt++;
        end else if (abort_clr) begin
          chk("R9 abort_clr without response", 32'd1, 32'd0);
        end
      end
      prev_hs = dn_valid && dn_ready;
      prev_rv = dn_rvalid;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 host_ready", {31'd0, host_ready}, 32'd1);
    chk("R1 dn_valid", {31'd0, dn_valid}, 32'd0);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 err_flag", {31'd0, err_flag}, 32'd0);
    chk("R1 abort_clr", {31'd0, abort_clr}, 32'd0);

    xact(1'b1, 17'h0_0002, 16'h0214, 2'd2, 32'hDEAD_BEEF, 1'b0); // R2 R3 dev 6
    xact(1'b0, 17'h0_0000, 16'h0A5D, 2'd0, 32'h0, 1'b0);         // R3 dev 0, lane 1
    xact(1'b0, 17'h0_0F00, 16'h4302, 2'd1, 32'h0, 1'b0);         // R3 lowest of many
    xact(1'b1, 17'h0_8000, 16'h0000, 2'd0, 32'h0000_00AB, 1'b0); // R3 dev 20
    @(posedge clk); #1 bus_num = 8'hA7;
    xact(1'b0, 17'h0_0001, 16'hF7F8, 2'd2, 32'h0, 1'b0);         // R2 bus change
    xact(1'b0, 17'h1_0002, 16'h0214, 2'd0, 32'h0, 1'b0);         // R4
    xact(1'b0, 17'h1_0002, 16'h0214, 2'd1, 32'h0, 1'b0);         // R4
    xact(1'b0, 17'h1_0002, 16'h0214, 2'd2, 32'h0, 1'b0);         // R4
    xact(1'b1, 17'h1_0002, 16'h0214, 2'd2, 32'h1234_5678, 1'b0); // R4 write dropped
    xact(1'b0, 17'h0_0000, 16'h07FC, 2'd1, 32'h0, 1'b0);         // R5
    xact(1'b0, 17'h0_0040, 16'h0108, 2'd2, 32'h0, 1'b0);         // R6 stays set
    clear_err();                                                  // R6
    xact(1'b1, 17'h0_0000, 16'h0004, 2'd2, 32'hCAFE_0001, 1'b0); // R5 write
    clear_err();
    xact(1'b0, 17'h0_0000, 16'h0100, 2'd0, 32'h0, 1'b1);         // R6 set wins
    xact(1'b1, 17'h0_0004, 16'h1F03, 2'd0, 32'h0000_0055, 1'b1); // R6 clear with good access
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R8 no leftover forward", 32'(dq.size()), 32'd0);
    chk("R9 no leftover response", 32'(rq.size()), 32'd0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule